// File: doc/BRIEF.md
# Memory-Mapped Parallel I/O Port with Edge Capture

This block is a general-purpose parallel I/O port of up to 32 pins, reached over a small register bus. Software sets each pin as an input or an output, writes the levels driven on output pins, and reads back the current pin levels. Inputs are brought into the clock domain through a two-stage synchronizer before anything else looks at them.

A single interrupt line reports pin activity. Its trigger mode is fixed by a parameter when the block is built: rising edge, falling edge, either edge, or high level. In the three edge modes, each detected edge sets a sticky capture bit, and software clears that bit by writing a one to it. In level mode the interrupt follows the masked pin levels directly. A per-pin enable mask gates which pins can raise the interrupt.

Top module: `pio_port`

## Requirements
- R1: After reset, direction, output, mask and capture all read as zero, `pin_oe` and `pin_out` are zero, and `irq` is low.
- R2: A write to byte offset 0x4 sets the direction bits. A direction bit of 1 drives `pin_oe` high for that pin, making it an output. A write to offset 0x0 sets the output register, which drives `pin_out`. Both keep their value unless their own offset is written.
- R3: A read pulse returns data on `bus_rdata` from the next clock edge onward. Offset 0x0 returns the output register bit for output pins and the synchronized input for input pins. Offsets 0x4, 0x8 and 0xC return direction, mask and capture.
- R4: A change on `pin_in` sets a capture bit at the third rising clock edge after the change, not before. In level mode the interrupt follows at the second edge.
- R5: The mode parameter TRIG_MODE selects which transitions set a capture bit: 0 for rising, 1 for falling, 2 for both. In mode 3 (level), no capture bit is ever set.
- R6: A write to offset 0xC clears each capture bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R7: If an edge on a pin arrives in the same cycle as a clearing write to that pin's capture bit, the bit stays set.
- R8: In the edge modes, `irq` is high exactly when some capture bit is set whose mask bit (offset 0x8, 1 = enabled) is also set. With the mask at zero, `irq` stays low.
- R9: In level mode, `irq` is high exactly when some enabled pin reads 1 in the data view of offset 0x0.
- R10: Register bits at or above N_PINS read as 0, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | N_PINS | Pin input levels (asynchronous) |
| pin_out | output | N_PINS | Output levels driven on the pins |
| pin_oe | output | N_PINS | Output enables, 1 = drive the pin |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency. A register write shows on `pin_oe` and `pin_out` one edge later. Read data arrives one edge after the read pulse. A pin change reaches the data view and the level interrupt two edges later, and the capture register three edges later. The bench changes inputs only on falling clock edges and counts rising edges before it samples. It checks one edge before each deadline that the result has not yet appeared. The simultaneous edge-and-clear case is built by timing the clearing write onto the third edge after a pin toggle.

// File: rtl/pio_port.sv
module pio_port #(
  parameter int N_PINS    = 32,
  parameter int TRIG_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);
  localparam int TRIG_RISE  = 0;
  localparam int TRIG_FALL  = 1;
  localparam int TRIG_BOTH  = 2;
  localparam int TRIG_LEVEL = 3;
  localparam logic [3:0] OFS_DATA = 4'h0;
  localparam logic [3:0] OFS_DIR  = 4'h4;
  localparam logic [3:0] OFS_MASK = 4'h8;
  localparam logic [3:0] OFS_CAP  = 4'hC;

  logic [N_PINS-1:0] out_q, dir_q, mask_q, cap_q;
  logic [N_PINS-1:0] sync1_q, sync2_q, prev_q;
  logic [N_PINS-1:0] edge_vec, pin_view, wbits, clr_vec;
  logic [31:0]       rmux;

  assign wbits    = bus_wdata[N_PINS-1:0];
  assign pin_view = (dir_q & out_q) | (~dir_q & sync2_q);
  assign pin_out  = out_q;
  assign pin_oe   = dir_q;
  assign clr_vec  = (bus_wr && bus_addr == OFS_CAP) ? wbits : '0;

  generate
    if (TRIG_MODE == TRIG_RISE) begin : g_rise
      assign edge_vec = sync2_q & ~prev_q;
    end else if (TRIG_MODE == TRIG_FALL) begin : g_fall
      assign edge_vec = ~sync2_q & prev_q;
    end else if (TRIG_MODE == TRIG_BOTH) begin : g_both
      assign edge_vec = sync2_q ^ prev_q;
    end else begin : g_level
      assign edge_vec = '0;
    end
    if (TRIG_MODE == TRIG_LEVEL) begin : g_irq_lvl
      assign irq = |(pin_view & mask_q);
    end else begin : g_irq_edge
      assign irq = |(cap_q & mask_q);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == OFS_DATA) out_q  <= wbits;
      if (bus_addr == OFS_DIR)  dir_q  <= wbits;
      if (bus_addr == OFS_MASK) mask_q <= wbits;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_q <= '0;
    else        cap_q <= (cap_q & ~clr_vec) | edge_vec;
  end

  always_comb begin
    case (bus_addr)
      OFS_DATA: rmux = 32'(pin_view);
      OFS_DIR:  rmux = 32'(dir_q);
      OFS_MASK: rmux = 32'(mask_q);
      OFS_CAP:  rmux = 32'(cap_q);
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rmux;
  end

  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> pin_oe == $past(bus_wdata[N_PINS-1:0])); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_DATA) |=> $stable(pin_out)); // R2
  AST_CAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == OFS_CAP) |=> ((cap_q & $past(cap_q)) == $past(cap_q))); // R6
  AST_CAP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_CAP) |=>
      ((cap_q & $past(bus_wdata[N_PINS-1:0]) & ~$past(edge_vec)) == '0)); // R6
  AST_MASK_GATES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq); // R8
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd) |-> ((64'(bus_rdata) >> N_PINS) == 64'd0)); // R10
endmodule

// File: tb/pio_port_tb.sv
module pio_port_tb;
  localparam int N = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [N-1:0] pins = '0;
  logic [3:0][31:0] rdv;
  logic [3:0][N-1:0] outv, oev;
  logic [3:0] irqv;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pio_port #(.N_PINS(N), .TRIG_MODE(0)) u_dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdv[0]),
    .pin_in(pins), .pin_out(outv[0]), .pin_oe(oev[0]), .irq(irqv[0]));
  pio_port #(.N_PINS(N), .TRIG_MODE(1)) u_dut_fall (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdv[1]),
    .pin_in(pins), .pin_out(outv[1]), .pin_oe(oev[1]), .irq(irqv[1]));
  pio_port #(.N_PINS(N), .TRIG_MODE(2)) u_dut_both (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdv[2]),
    .pin_in(pins), .pin_out(outv[2]), .pin_oe(oev[2]), .irq(irqv[2]));
  pio_port #(.N_PINS(N), .TRIG_MODE(3)) u_dut_lvl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdv[3]),
    .pin_in(pins), .pin_out(outv[3]), .pin_oe(oev[3]), .irq(irqv[3]));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int d = 0; d < 4; d++) begin
      chk(irqv[d] == 1'b0, "R1 irq", 32'(irqv[d]), 0);
      chk(oev[d] == '0 && outv[d] == '0, "R1 pins", 32'({oev[d], outv[d]}), 0);
    end
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4));
      for (int d = 0; d < 4; d++) chk(rdv[d] == 0, "R1 regs", rdv[d], 0);
    end
    // R2 direction and output drive, R3 data mux
    wr(4'h4, 32'hFFFF_FFFA);
    chk(oev[0] == 4'hA, "R2 oe", 32'(oev[0]), 32'hA);
    wr(4'h0, 32'h6);
    chk(outv[0] == 4'h6, "R2 out", 32'(outv[0]), 32'h6);
    pins = 4'h5;
    ticks(3);
    rd(4'h0);
    exp = (4'hA & 4'h6) | (~4'hA & 4'h5);
    chk(rdv[0] == 32'(exp), "R3 data mux", rdv[0], 32'(exp));
    rd(4'h4);
    chk(rdv[0] == 32'hA, "R10 upper dir bits", rdv[0], 32'hA);
    rd(4'h2);
    chk(rdv[0] == 0, "R10 unmapped address", rdv[0], 0);
    wr(4'h8, 32'h3);
    chk(oev[0] == 4'hA && outv[0] == 4'h6, "R2 hold on other write", 32'({oev[0], outv[0]}), 32'hA6);
    // R9 level irq via output pin view
    wr(4'h8, 32'h2);
    chk(irqv[3] == 1'b1, "R9 level from output", 32'(irqv[3]), 1);
    wr(4'h4, 0); wr(4'h0, 0); wr(4'h8, 0);
    pins = 4'h0;
    ticks(4);
    wr(4'hC, 32'hF);
    // R8 mask zero keeps irq low despite capture
    pins = 4'h1;
    ticks(4);
    rd(4'hC);
    chk(rdv[0] == 32'h1, "R5 rise capture", rdv[0], 1);
    chk(irqv[0] == 1'b0 && irqv[3] == 1'b0, "R8 masked irq", 32'(irqv), 0);
    wr(4'h8, 32'hF);
    chk(irqv[0] == 1'b1, "R8 unmasked irq", 32'(irqv[0]), 1);
    // R6 partial clear
    pins = 4'h3;
    ticks(4);
    wr(4'hC, 32'h1);
    rd(4'hC);
    chk(rdv[0] == 32'h2, "R6 partial clear", rdv[0], 32'h2);
    wr(4'hC, 32'hF);
    rd(4'hC);
    chk(rdv[0] == 0, "R6 full clear", rdv[0], 0);
    chk(irqv[0] == 1'b0, "R8 irq drops", 32'(irqv[0]), 0);
    // R4 latency: falling to 0x0 at a negedge
    @(negedge clk); pins = 4'h0;
    @(posedge clk); @(negedge clk);
    chk(irqv[3] == 1'b1, "R4 level not yet cleared", 32'(irqv[3]), 1);
    @(posedge clk); @(negedge clk);
    chk(irqv[1] == 1'b0, "R4 capture before third edge", 32'(irqv[1]), 0);
    chk(irqv[3] == 1'b0, "R4 level at second edge", 32'(irqv[3]), 0);
    @(posedge clk); @(negedge clk);
    chk(irqv[1] == 1'b1, "R4 capture at third edge", 32'(irqv[1]), 1);
    wr(4'hC, 32'hF);
    // R7 edge in same cycle as clear
    @(negedge clk); pins = 4'h1;
    @(posedge clk); @(posedge clk);
    wr(4'hC, 32'h1);
    rd(4'hC);
    chk(rdv[2][0] == 1'b1, "R7 both-edge kept", rdv[2], 1);
    chk(rdv[0][0] == 1'b1, "R7 rise kept", rdv[0], 1);
    wr(4'hC, 32'hF);
    // R5, R8, R9, R3: exhaustive sweep over pin transitions
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        pins = 4'(a);
        ticks(4);
        wr(4'hC, 32'hF);
        pins = 4'(b);
        ticks(4);
        rd(4'hC);
        exp = 4'(b) & ~4'(a);
        chk(rdv[0] == 32'(exp), "R5 rise sweep", rdv[0], 32'(exp));
        chk(irqv[0] == (exp != 0), "R8 rise irq sweep", 32'(irqv[0]), 32'(exp != 0));
        exp = 4'(a) & ~4'(b);
        chk(rdv[1] == 32'(exp), "R5 fall sweep", rdv[1], 32'(exp));
        exp = 4'(a) ^ 4'(b);
        chk(rdv[2] == 32'(exp), "R5 both sweep", rdv[2], 32'(exp));
        chk(rdv[3] == 0, "R5 level no capture", rdv[3], 0);
        chk(irqv[3] == (b != 0), "R9 level sweep", 32'(irqv[3]), 32'(b != 0));
        rd(4'h0);
        chk(rdv[3] == 32'(b), "R3 input view sweep", rdv[3], 32'(b));
      end
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule